// File: doc/BRIEF.md
# Double-Buffered Frequency Control Port

This block is the byte-wide, write-only control port of a numerically controlled oscillator. A host places one byte at a time into a set of shadow registers that together form two 48-bit words: the carrier (centre) frequency word and the offset frequency word. The oscillator core never reads the shadow registers. It reads a second copy of the words, the live registers, which change only when the host raises a separate commit input.

A raised commit copies both shadow words into the live words on one clock edge. A frequency change that spans several bytes, or both words, therefore reaches the core as one indivisible step. The byte strobe and the commit input may come from a host that is not timed to the core clock. Each one passes through a two-flop synchroniser, and only its rising edge acts, so each pulse performs exactly one action. The address, data and enable travel through the same two-stage delay so that they stay aligned with the strobe.

Top module: `freq_ctrl_port`

## Requirements
- R1: While reset is asserted, and after reset is released, both shadow words and both live words are zero until a write or a commit acts.
- R2: A byte is stored only if the byte-enable input is high at the rising edge of the strobe. A strobe edge while the enable is low changes nothing.
- R3: Address n in the range 0 to 5 writes byte n of the centre word, with byte 0 at bits 7:0 (least significant first). Address 6+n in the range 6 to 11 writes byte n of the offset word in the same order.
- R4: A write to an address from 12 to 15 changes neither word.
- R5: Writes alone never change the live output words, however many bytes have been written.
- R6: A commit updates all twelve bytes of both live words on the same clock edge. This is the third rising clock edge that sees the commit input high. After that edge the live words equal the shadow words.
- R7: When a write and a commit act on the same clock, the commit carries the newly written byte.
- R8: A strobe or commit held high for several cycles acts once, on its rising edge. Data that changes while the strobe stays high is not stored, and a write made while the commit input stays high does not reach the live words.
- R9: Byte writes issued every second clock cycle (strobe high one cycle, low one cycle) are all stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata | input | 8 | Byte to be written |
| waddr | input | 4 | Byte address (see R3, R4) |
| wr_strobe | input | 1 | Write strobe; rising edge acts |
| wr_en | input | 1 | Byte enable qualifying the strobe |
| commit | input | 1 | Copies shadow words to live words; rising edge acts |
| center_word | output | 48 | Live centre frequency word |
| offset_word | output | 48 | Live offset frequency word |

## Verification
Each path holds three registers: two synchroniser stages and the target register. A strobe or commit that is first sampled at edge n therefore has its effect visible after edge n+2, the third edge. When the driver raises a commit, it pushes a snapshot of the expected live words and stamps it with the cycle in which the result is due. The monitor compares the outputs with that snapshot in exactly that cycle, and it samples on the falling edge. In every other cycle it requires the outputs to equal the last committed value, so a change that is early, late or unrequested is reported as a mismatch.

// File: rtl/freq_ctrl_port.sv
module freq_ctrl_port #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int WORD_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wr_strobe,
  input  logic              wr_en,
  input  logic              commit,
  output logic [WORD_W-1:0] center_word,
  output logic [WORD_W-1:0] offset_word
);
  localparam int NBYTES = WORD_W / DATA_W;
  localparam int NADDR  = 2 * NBYTES;

  logic [2:0]        stb_sh, cmt_sh;
  logic [DATA_W-1:0] d_p1, d_p2;
  logic [ADDR_W-1:0] a_p1, a_p2;
  logic              en_p1, en_p2;
  logic [WORD_W-1:0] cen_m, ofs_m, cen_m_nxt, ofs_m_nxt;
  logic              wr_pulse, cmt_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_sh <= '0;
      cmt_sh <= '0;
      d_p1   <= '0;
      d_p2   <= '0;
      a_p1   <= '0;
      a_p2   <= '0;
      en_p1  <= 1'b0;
      en_p2  <= 1'b0;
    end else begin
      stb_sh <= {stb_sh[1:0], wr_strobe};
      cmt_sh <= {cmt_sh[1:0], commit};
      d_p1   <= wdata;
      d_p2   <= d_p1;
      a_p1   <= waddr;
      a_p2   <= a_p1;
      en_p1  <= wr_en;
      en_p2  <= en_p1;
    end
  end

  assign wr_pulse  = stb_sh[1] & ~stb_sh[2] & en_p2;
  assign cmt_pulse = cmt_sh[1] & ~cmt_sh[2];

  always_comb begin
    cen_m_nxt = cen_m;
    ofs_m_nxt = ofs_m;
    if (wr_pulse) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (a_p2 == ADDR_W'(i))          cen_m_nxt[i*DATA_W +: DATA_W] = d_p2;
        if (a_p2 == ADDR_W'(NBYTES + i)) ofs_m_nxt[i*DATA_W +: DATA_W] = d_p2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen_m       <= '0;
      ofs_m       <= '0;
      center_word <= '0;
      offset_word <= '0;
    end else begin
      cen_m <= cen_m_nxt;
      ofs_m <= ofs_m_nxt;
      if (cmt_pulse) begin
        center_word <= cen_m_nxt;
        offset_word <= ofs_m_nxt;
      end
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (center_word == '0 && offset_word == '0 && cen_m == '0 && ofs_m == '0));

  p_idle_shadow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> ($stable(cen_m) && $stable(ofs_m)));

  p_high_addr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && a_p2 >= ADDR_W'(NADDR)) |=> ($stable(cen_m) && $stable(ofs_m)));

  p_live_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_pulse |=> ($stable(center_word) && $stable(offset_word)));

  p_commit_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_pulse && !wr_pulse) |=> (center_word == cen_m && offset_word == ofs_m));

  p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_pulse && wr_pulse && a_p2 == '0) |=> (center_word[DATA_W-1:0] == $past(d_p2)));

  p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  p_single_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_pulse |=> !cmt_pulse);
endmodule

// File: tb/freq_ctrl_port_tb.sv
module freq_ctrl_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  typedef struct {
    int          due;
    logic [47:0] c;
    logic [47:0] o;
    int          req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  wdata = '0;
  logic [3:0]  waddr = '0;
  logic        wr_strobe = 1'b0;
  logic        wr_en = 1'b0;
  logic        commit = 1'b0;
  logic [47:0] center_word, offset_word;

  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  item_t sb[$];
  logic [47:0] mc = '0, mo = '0, sc = '0, so = '0;
  logic [47:0] exp_c = '0, exp_o = '0;

  freq_ctrl_port dut_i (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .waddr(waddr),
    .wr_strobe(wr_strobe), .wr_en(wr_en), .commit(commit),
    .center_word(center_word), .offset_word(offset_word)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic model_write(input logic [3:0] a, input logic [7:0] d, input logic en);
    int idx;
    idx = int'(a);
    if (en) begin
      if (idx < 6)       mc[idx*8 +: 8] = d;
      else if (idx < 12) mo[(idx-6)*8 +: 8] = d;
    end
  endtask

  task automatic push(input int req);
    item_t it;
    it.due = cyc + LAT; it.c = sc; it.o = so; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    waddr = a; wdata = d; wr_en = en; wr_strobe = 1'b1;
    model_write(a, d, en);
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic do_commit(input int req);
    @(negedge clk);
    commit = 1'b1;
    sc = mc; so = mo;
    push(req);
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic wr_commit(input logic [3:0] a, input logic [7:0] d, input int req);
    @(negedge clk);
    waddr = a; wdata = d; wr_en = 1'b1; wr_strobe = 1'b1; commit = 1'b1;
    model_write(a, d, 1'b1);
    sc = mc; so = mo;
    push(req);
    @(negedge clk);
    wr_strobe = 1'b0; commit = 1'b0;
  endtask

  task automatic hold_check(input int req);
    @(negedge clk);
    push(req);
  endtask

  // Monitor: pops items in their due cycle, checks stability otherwise
  always @(negedge clk) begin
    if (rst_n) begin
      bit popped_bad;
      popped_bad = 1'b0;
      if (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        exp_c = it.c; exp_o = it.o;
        n_cmp++;
        if (center_word !== it.c || offset_word !== it.o) begin
          n_bad++; popped_bad = 1'b1;
          $display("FAIL R%0d cycle %0d: center %h offset %h expected %h %h",
                   it.req, cyc, center_word, offset_word, it.c, it.o);
        end
      end
      if (!popped_bad && (center_word !== exp_c || offset_word !== exp_o)) begin
        n_bad++;
        $display("FAIL R5 cycle %0d: live words %h %h expected unchanged %h %h",
                 cyc, center_word, offset_word, exp_c, exp_o);
        exp_c = center_word; exp_o = offset_word;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog expired: got %0d items pending, expected 0", sb.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(1);                                   // R1: zero after reset
    // R5: partial centre word stays hidden
    wr(4'd0, 8'h11, 1'b1); wr(4'd1, 8'h22, 1'b1); wr(4'd2, 8'h33, 1'b1);
    hold_check(5);
    // R3: remaining bytes, both words, least significant first
    wr(4'd3, 8'h44, 1'b1); wr(4'd4, 8'h55, 1'b1); wr(4'd5, 8'h66, 1'b1);
    for (int i = 0; i < 6; i++) wr(4'(6 + i), 8'(8'hA0 + i), 1'b1);
    hold_check(5);
    do_commit(3);
    // R2: strobe without enable is ignored
    wr(4'd0, 8'hFF, 1'b0); wr(4'd7, 8'hEE, 1'b0);
    do_commit(2);
    // R4: high addresses ignored
    for (int i = 12; i < 16; i++) wr(4'(i), 8'h77, 1'b1);
    do_commit(4);
    // R9 and R6: back-to-back writes, all twelve bytes commit together
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 12; i++) wr(4'(i), 8'((r * 37 + i * 13 + 5) & 8'hFF), 1'b1);
      hold_check(9);
      do_commit(6);
    end
    // R8: strobe held high, later data ignored
    @(negedge clk);
    waddr = 4'd0; wdata = 8'hC3; wr_en = 1'b1; wr_strobe = 1'b1;
    model_write(4'd0, 8'hC3, 1'b1);
    @(negedge clk); wdata = 8'h3C;
    @(negedge clk); wdata = 8'h99;
    @(negedge clk); wr_strobe = 1'b0;
    do_commit(8);
    // R8: commit held high, a write during it must not reach live words
    @(negedge clk);
    commit = 1'b1; sc = mc; so = mo; push(8);
    @(negedge clk);
    wr(4'd1, 8'h5E, 1'b1);
    @(negedge clk); commit = 1'b0;
    hold_check(8);
    // R7: write and commit on the same clock
    wr_commit(4'd0, 8'h5A, 7);
    wr_commit(4'd11, 8'hB7, 7);
    repeat (10) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R6 items left: got %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule